// File: doc/BRIEF.md
# Drive Tag Interface and Unit Selection

This block is the drive end of the command link to a disk controller. A 4-bit tag code with its parity line arrives under a tag gate. An 8-bit bus-out byte with its own parity arrives with it. The block checks both parity paths for odd parity. It turns a well-formed tag into a registered tag-valid flag and a one-hot strobe vector, and it holds the bus-out byte for downstream logic. It also gates a command-valid flag, which needs the unit to be selected. The operate tag is exempt from the bus-out parity rule.

Selection is handled by a three-state machine. The states are ST_FREE (not attached), ST_SELECTED (attached to the controller) and ST_RESERVED (was attached, then displaced by a select addressed to another unit). The transitions are:
- T_SELECT: ST_FREE to ST_SELECTED on a matching select.
- T_RELEASE: ST_SELECTED to ST_RESERVED on a select with a different address.
- T_RESELECT: ST_RESERVED to ST_SELECTED on a matching select.
- T_CLEAR: ST_RESERVED to ST_FREE on a general reset.

A general reset never touches ST_SELECTED.

While selected, the block returns a fixed 3-of-6 location pattern on bus-in. A poll tag with a pending interrupt makes the unit answer with its address bit, whether or not it is selected. Bus-in always carries odd parity.

Top module: `drive_tag_port`

## Requirements
- R1: `tag_valid` rises one clock after an edge at which `tag_gate` is high, `tag_code` is nonzero and the five bits {`tag_code`,`tag_par`} hold an odd number of ones; otherwise it is low.
- R2: `tag_strobe` is registered in step with `tag_valid`. It has exactly bit N set when a valid tag of code N was sampled, and it is all zero otherwise.
- R3: A select (valid tag code 3, `mod_sel` high, odd parity over {`bus_out`,`bo_par`}, and `bus_out` equal to the one-hot byte with only bit LOG_ADDR set) moves ST_FREE or ST_RESERVED to ST_SELECTED. The `selected` output is high from the next clock.
- R4: In ST_SELECTED, a select that is well formed but carries any other `bus_out` value moves the unit to ST_RESERVED (`reserved` high, `selected` low). `selected` and `reserved` are never high together.
- R5: `gen_reset` moves ST_RESERVED to ST_FREE. It has no effect in ST_SELECTED or ST_FREE. A matching select in the same cycle takes priority over it.
- R6: While selected and not answering a poll, `bus_in` bits 2..7 carry the location pattern of LOC_ID, listed as bits 2,3,4,5,6,7: 0=111000, 1=110001, 2=101010, 3=100011, 4=011100, 5=010101, 6=001110, 7=000111. Bits 0 and 1 are zero.
- R7: A poll (valid tag code 2, `bus_out` bit 7 high, good bus-out parity, `intr_pend` high) makes `bus_in` equal to the byte with only bit LOG_ADDR set for exactly the next cycle. This happens in any selection state.
- R8: `bus_in` is zero when neither R6 nor R7 applies. `bi_par` always makes {`bus_in`,`bi_par`} odd.
- R9: `cmd_valid` is high one clock after a valid tag whose code is neither 2 nor 3, sampled while the unit was selected, with good bus-out parity. For tag code 11 the bus-out parity is not required.
- R10: A valid tag with bad bus-out parity and a code other than 11 sets `if_check`. `if_check` then stays high until `rst_n`, and the tag yields no command, select or poll answer.
- R11: `bo_hold` captures `bus_out` at every edge where a valid tag is sampled and holds it otherwise.
- R12: After `rst_n` low, every output is zero except `bi_par`, which is 1, and the unit is in ST_FREE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tag_code | input | 4 | Tag code from controller |
| tag_par | input | 1 | Tag parity (odd over five bits) |
| tag_gate | input | 1 | Tag gate |
| bus_out | input | 8 | Command byte from controller |
| bo_par | input | 1 | Bus-out parity (odd over nine bits) |
| mod_sel | input | 1 | Module-select line |
| gen_reset | input | 1 | General reset for unselected units |
| intr_pend | input | 1 | Unit has a pending interrupt |
| tag_valid | output | 1 | Registered well-formed tag flag |
| tag_strobe | output | 16 | One-hot decoded tag |
| cmd_valid | output | 1 | Command accepted for downstream |
| bo_hold | output | 8 | Bus-out byte held for downstream |
| if_check | output | 1 | Sticky interface-check flag |
| selected | output | 1 | Unit in ST_SELECTED |
| reserved | output | 1 | Unit in ST_RESERVED |
| bus_in | output | 8 | Response byte to controller |
| bi_par | output | 1 | Bus-in odd parity |

## Verification
The bench targets the following corner cases:
- Operate tag with bad bus-out parity: a design that skipped the exemption would drop the command and raise `if_check`.
- General reset while selected: a design that cleared the wrong state would drop the selection and blank the location code.
- Poll answered while free and while selected: a design that tied polling to selection would stay silent, and one that let the answer linger would corrupt the next location-code read.
- Bad tag parity, missing `mod_sel`, and a select addressed to another unit: any of these slipping through would show up as a wrong `selected`/`reserved` pair or a nonzero `bus_in` when free.

// File: rtl/dti_pkg.sv
package dti_pkg;

    typedef enum logic [1:0] {
        ST_FREE     = 2'd0,
        ST_SELECTED = 2'd1,
        ST_RESERVED = 2'd2
    } sel_state_t;

    // 3-of-6 location pattern placed on response bits 2..7
    function automatic logic [7:0] loc_pattern(input logic [2:0] id);
        logic [7:0] p;
        unique case (id)
            3'd0: p = 8'b0001_1100;
            3'd1: p = 8'b1000_1100;
            3'd2: p = 8'b0101_0100;
            3'd3: p = 8'b1100_0100;
            3'd4: p = 8'b0011_1000;
            3'd5: p = 8'b1010_1000;
            3'd6: p = 8'b0111_0000;
            default: p = 8'b1110_0000;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/dti_tag_decode.sv
module dti_tag_decode #(
    parameter int TAG_W = 4,
    parameter int BUS_W = 8,
    localparam int NTAG = 1 << TAG_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TAG_W-1:0] tag_code,
    input  logic             tag_par,
    input  logic             tag_gate,
    input  logic [BUS_W-1:0] bus_out,
    input  logic             bo_par,
    output logic             tv_c,
    output logic             bo_ok_c,
    output logic             tag_valid,
    output logic [NTAG-1:0]  tag_strobe
);

    logic [NTAG-1:0] strobe_c;

    assign tv_c    = tag_gate && (tag_code != '0) && (^{tag_code, tag_par});
    assign bo_ok_c = ^{bus_out, bo_par};

    for (genvar g = 0; g < NTAG; g++) begin : g_strobe
        assign strobe_c[g] = tv_c && (tag_code == TAG_W'(g));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tag_valid  <= 1'b0;
            tag_strobe <= '0;
        end else begin
            tag_valid  <= tv_c;
            tag_strobe <= strobe_c;
        end
    end

    p_strobe_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(tag_strobe));
    p_strobe_needs_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (|tag_strobe) |-> tag_valid);
    p_valid_needs_gate_r1: assert property (@(posedge clk) disable iff (!rst_n)
        tag_gate |=> (tag_valid || !$past(tv_c)));

endmodule

// File: rtl/dti_select_fsm.sv
module dti_select_fsm
    import dti_pkg::*;
#(
    parameter int TAG_W    = 4,
    parameter int BUS_W    = 8,
    parameter int SEL_TAG  = 3,
    parameter int LOG_ADDR = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tv_c,
    input  logic             bo_ok_c,
    input  logic [TAG_W-1:0] tag_code,
    input  logic [BUS_W-1:0] bus_out,
    input  logic             mod_sel,
    input  logic             gen_reset,
    output logic             selected,
    output logic             reserved
);

    localparam logic [BUS_W-1:0] ADDR_BYTE = BUS_W'(1) << LOG_ADDR;

    sel_state_t state_q, state_d;
    logic       sel_cmd, sel_hit, sel_miss;

    assign sel_cmd  = tv_c && bo_ok_c && mod_sel && (tag_code == TAG_W'(SEL_TAG));
    assign sel_hit  = sel_cmd && (bus_out == ADDR_BYTE);
    assign sel_miss = sel_cmd && (bus_out != ADDR_BYTE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_FREE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FREE: begin
                if (sel_hit) state_d = ST_SELECTED;          // T_SELECT
            end
            ST_SELECTED: begin
                if (sel_miss) state_d = ST_RESERVED;         // T_RELEASE
            end
            ST_RESERVED: begin
                if (sel_hit)        state_d = ST_SELECTED;   // T_RESELECT
                else if (gen_reset) state_d = ST_FREE;       // T_CLEAR
            end
            default: state_d = ST_FREE;
        endcase
    end

    assign selected = (state_q == ST_SELECTED);
    assign reserved = (state_q == ST_RESERVED);

    p_sel_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(selected && reserved));
    p_reserve_from_sel_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(reserved) |-> $past(selected));
    p_genreset_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (selected && gen_reset && !sel_cmd) |=> selected);
    p_select_hit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sel_hit |=> selected);

endmodule

// File: rtl/dti_cmd_gate.sv
module dti_cmd_gate #(
    parameter int TAG_W    = 4,
    parameter int BUS_W    = 8,
    parameter int SEL_TAG  = 3,
    parameter int POLL_TAG = 2,
    parameter int OP_TAG   = 11,
    parameter int POLL_BIT = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tv_c,
    input  logic             bo_ok_c,
    input  logic [TAG_W-1:0] tag_code,
    input  logic [BUS_W-1:0] bus_out,
    input  logic             selected,
    input  logic             intr_pend,
    output logic             cmd_valid,
    output logic             if_check,
    output logic             poll_q,
    output logic [BUS_W-1:0] bo_hold
);

    logic is_op, is_sel, is_poll, par_pass, cmd_c, poll_c, bad_c;

    assign is_op    = (tag_code == TAG_W'(OP_TAG));
    assign is_sel   = (tag_code == TAG_W'(SEL_TAG));
    assign is_poll  = (tag_code == TAG_W'(POLL_TAG));
    assign par_pass = bo_ok_c || is_op;
    assign cmd_c    = tv_c && selected && par_pass && !is_sel && !is_poll;
    assign poll_c   = tv_c && is_poll && bo_ok_c && bus_out[POLL_BIT] && intr_pend;
    assign bad_c    = tv_c && !par_pass;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_valid <= 1'b0;
            if_check  <= 1'b0;
            poll_q    <= 1'b0;
            bo_hold   <= '0;
        end else begin
            cmd_valid <= cmd_c;
            poll_q    <= poll_c;
            if (bad_c) if_check <= 1'b1;
            if (tv_c)  bo_hold  <= bus_out;
        end
    end

    p_ifchk_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        if_check |=> if_check);
    p_cmd_needs_sel_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> $past(selected));
    p_hold_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !tv_c |=> $stable(bo_hold));

endmodule

// File: rtl/dti_bus_in.sv
module dti_bus_in
    import dti_pkg::*;
#(
    parameter int BUS_W    = 8,
    parameter int LOG_ADDR = 5,
    parameter int LOC_ID   = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             selected,
    input  logic             poll_q,
    output logic [BUS_W-1:0] bus_in,
    output logic             bi_par
);

    localparam logic [BUS_W-1:0] ADDR_BYTE = BUS_W'(1) << LOG_ADDR;
    localparam logic [BUS_W-1:0] LOC_BYTE  = BUS_W'(loc_pattern(3'(LOC_ID)));

    always_comb begin
        if (poll_q)        bus_in = ADDR_BYTE;
        else if (selected) bus_in = LOC_BYTE;
        else               bus_in = '0;
    end

    assign bi_par = ~^bus_in;

    p_bi_odd_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ^{bus_in, bi_par});
    p_loc_weight_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (selected && !poll_q) |-> ($countones(bus_in) == 3));
    p_poll_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        poll_q |-> ($countones(bus_in) == 1));

endmodule

// File: rtl/drive_tag_port.sv
module drive_tag_port #(
    parameter int TAG_W    = 4,
    parameter int BUS_W    = 8,
    parameter int LOG_ADDR = 5,
    parameter int LOC_ID   = 3,
    parameter int SEL_TAG  = 3,
    parameter int POLL_TAG = 2,
    parameter int OP_TAG   = 11,
    parameter int POLL_BIT = 7,
    localparam int NTAG    = 1 << TAG_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TAG_W-1:0] tag_code,
    input  logic             tag_par,
    input  logic             tag_gate,
    input  logic [BUS_W-1:0] bus_out,
    input  logic             bo_par,
    input  logic             mod_sel,
    input  logic             gen_reset,
    input  logic             intr_pend,
    output logic             tag_valid,
    output logic [NTAG-1:0]  tag_strobe,
    output logic             cmd_valid,
    output logic [BUS_W-1:0] bo_hold,
    output logic             if_check,
    output logic             selected,
    output logic             reserved,
    output logic [BUS_W-1:0] bus_in,
    output logic             bi_par
);

    logic tv_c, bo_ok_c, poll_q;

    dti_tag_decode #(.TAG_W(TAG_W), .BUS_W(BUS_W)) u_dec (
        .clk(clk), .rst_n(rst_n), .tag_code(tag_code), .tag_par(tag_par),
        .tag_gate(tag_gate), .bus_out(bus_out), .bo_par(bo_par),
        .tv_c(tv_c), .bo_ok_c(bo_ok_c), .tag_valid(tag_valid),
        .tag_strobe(tag_strobe)
    );

    dti_select_fsm #(.TAG_W(TAG_W), .BUS_W(BUS_W), .SEL_TAG(SEL_TAG),
                     .LOG_ADDR(LOG_ADDR)) u_fsm (
        .clk(clk), .rst_n(rst_n), .tv_c(tv_c), .bo_ok_c(bo_ok_c),
        .tag_code(tag_code), .bus_out(bus_out), .mod_sel(mod_sel),
        .gen_reset(gen_reset), .selected(selected), .reserved(reserved)
    );

    dti_cmd_gate #(.TAG_W(TAG_W), .BUS_W(BUS_W), .SEL_TAG(SEL_TAG),
                   .POLL_TAG(POLL_TAG), .OP_TAG(OP_TAG),
                   .POLL_BIT(POLL_BIT)) u_cmd (
        .clk(clk), .rst_n(rst_n), .tv_c(tv_c), .bo_ok_c(bo_ok_c),
        .tag_code(tag_code), .bus_out(bus_out), .selected(selected),
        .intr_pend(intr_pend), .cmd_valid(cmd_valid), .if_check(if_check),
        .poll_q(poll_q), .bo_hold(bo_hold)
    );

    dti_bus_in #(.BUS_W(BUS_W), .LOG_ADDR(LOG_ADDR), .LOC_ID(LOC_ID)) u_bi (
        .clk(clk), .rst_n(rst_n), .selected(selected), .poll_q(poll_q),
        .bus_in(bus_in), .bi_par(bi_par)
    );

endmodule

// File: tb/drive_tag_port_bench.sv
`timescale 1ns/1ps
module drive_tag_port_bench;

    localparam int LA  = 5;
    localparam int LOC = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  tag_code = '0;
    logic        tag_par = 1'b0, tag_gate = 1'b0;
    logic [7:0]  bus_out = '0;
    logic        bo_par = 1'b0, mod_sel = 1'b0, gen_reset = 1'b0, intr_pend = 1'b0;
    logic        tag_valid, cmd_valid, if_check, selected, reserved, bi_par;
    logic [15:0] tag_strobe;
    logic [7:0]  bo_hold, bus_in;

    always #2.5 clk = ~clk;

    drive_tag_port u_drive_tag_port (
        .clk(clk), .rst_n(rst_n), .tag_code(tag_code), .tag_par(tag_par),
        .tag_gate(tag_gate), .bus_out(bus_out), .bo_par(bo_par),
        .mod_sel(mod_sel), .gen_reset(gen_reset), .intr_pend(intr_pend),
        .tag_valid(tag_valid), .tag_strobe(tag_strobe), .cmd_valid(cmd_valid),
        .bo_hold(bo_hold), .if_check(if_check), .selected(selected),
        .reserved(reserved), .bus_in(bus_in), .bi_par(bi_par)
    );

    int checks = 0, fails = 0;
    bit done = 0;

    // model state: 0 free, 1 selected, 2 reserved
    int         m_st = 0;
    logic       m_ifc = 0;
    logic [7:0] m_bo = '0;
    logic       e_tv, e_cmd, e_poll;
    logic [15:0] e_strobe;

    function automatic logic [7:0] exp_loc(input int id);
        logic [5:0] pat;   // leftmost char = bus-in bit 2
        logic [7:0] r;
        case (id)
            0: pat = 6'b111000; 1: pat = 6'b110001; 2: pat = 6'b101010;
            3: pat = 6'b100011; 4: pat = 6'b011100; 5: pat = 6'b010101;
            6: pat = 6'b001110; default: pat = 6'b000111;
        endcase
        r = '0;
        for (int i = 0; i < 6; i++) r[2+i] = pat[5-i];
        return r;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic check_all();
        logic [7:0] e_bi;
        chk("R1 tag_valid", 32'(tag_valid), 32'(e_tv));
        chk("R2 tag_strobe", 32'(tag_strobe), 32'(e_strobe));
        chk("R3 selected", 32'(selected), 32'(m_st == 1));
        chk("R4 reserved", 32'(reserved), 32'(m_st == 2));
        e_bi = e_poll ? (8'd1 << LA) : (m_st == 1) ? exp_loc(LOC) : 8'd0;
        chk(e_poll ? "R7 bus_in poll" : (m_st == 1) ? "R6 bus_in loc" : "R8 bus_in idle",
            32'(bus_in), 32'(e_bi));
        chk("R8 bi_par", 32'(bi_par), 32'(~^e_bi));
        chk("R9 cmd_valid", 32'(cmd_valid), 32'(e_cmd));
        chk("R10 if_check", 32'(if_check), 32'(m_ifc));
        chk("R11 bo_hold", 32'(bo_hold), 32'(m_bo));
    endtask

    task automatic step(input logic [3:0] c, input logic tp, input logic tg,
                        input logic [7:0] bo, input logic bp, input logic ms,
                        input logic gr, input logic ip);
        logic tv, ok, hit, sc;
        tag_code = c; tag_par = tp; tag_gate = tg; bus_out = bo; bo_par = bp;
        mod_sel = ms; gen_reset = gr; intr_pend = ip;
        tv  = tg && (c != 0) && (^{c, tp});
        ok  = ^{bo, bp};
        sc  = tv && ok && ms && (c == 4'd3);
        hit = sc && (bo == (8'd1 << LA));
        e_tv     = tv;
        e_strobe = tv ? (16'd1 << c) : 16'd0;
        e_cmd    = tv && (m_st == 1) && (c != 4'd2) && (c != 4'd3) && (ok || c == 4'd11);
        e_poll   = tv && (c == 4'd2) && ok && bo[7] && ip;
        if (tv && !ok && c != 4'd11) m_ifc = 1'b1;
        if (tv) m_bo = bo;
        case (m_st)
            0: if (hit) m_st = 1;
            1: if (sc && !hit) m_st = 2;
            default: if (hit) m_st = 1; else if (gr) m_st = 0;
        endcase
        @(posedge clk);
        #1;
        check_all();
        @(negedge clk);
    endtask

    // well-formed tag with correct parities
    task automatic good(input logic [3:0] c, input logic [7:0] bo, input logic ms,
                        input logic gr, input logic ip);
        step(c, ~^c, 1'b1, bo, ~^bo, ms, gr, ip);
    endtask

    task automatic idle();
        step(4'd0, 1'b1, 1'b0, 8'd0, 1'b1, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        tag_gate = 1'b0; gen_reset = 1'b0;
        repeat (2) @(negedge clk);
        m_st = 0; m_ifc = 0; m_bo = '0; e_tv = 0; e_cmd = 0; e_poll = 0; e_strobe = '0;
        // R12 reset state
        chk("R12 reset tag_valid", 32'(tag_valid), 0);
        chk("R12 reset selected", 32'(selected), 0);
        chk("R12 reset bus_in", 32'(bus_in), 0);
        chk("R12 reset bi_par", 32'(bi_par), 1);
        chk("R12 reset if_check", 32'(if_check), 0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        do_reset();
        // directed corner cases
        good(4'd3, 8'd1 << LA, 1'b1, 1'b0, 1'b0);       // R3 select
        good(4'd9, 8'h04, 1'b0, 1'b0, 1'b0);            // R9 command
        step(4'd11, ~^4'd11, 1'b1, 8'h24, ^8'h24, 1'b0, 1'b0, 1'b0); // R9/R10 operate exempt
        good(4'd2, 8'h80, 1'b0, 1'b0, 1'b1);            // R7 poll while selected
        idle();                                          // R7 one cycle only
        good(4'd0, 8'h00, 1'b0, 1'b1, 1'b0);            // R5 gen_reset while selected
        idle();
        good(4'd3, 8'h02, 1'b1, 1'b0, 1'b0);            // R4 displaced
        good(4'd9, 8'h04, 1'b0, 1'b0, 1'b0);            // R9 no command when reserved
        good(4'd0, 8'h00, 1'b0, 1'b1, 1'b0);            // R5 clear to free
        step(4'd3, ^4'd3, 1'b1, 8'd1 << LA, ~^(8'd1 << LA), 1'b1, 1'b0, 1'b0); // R1 bad tag parity
        good(4'd3, 8'd1 << LA, 1'b0, 1'b0, 1'b0);       // R3 no mod_sel
        good(4'd2, 8'h80, 1'b0, 1'b0, 1'b1);            // R7 poll while free
        good(4'd2, 8'h80, 1'b0, 1'b0, 1'b0);            // R7 no interrupt
        step(4'd3, ~^4'd3, 1'b0, 8'd1 << LA, ~^(8'd1 << LA), 1'b1, 1'b0, 1'b0); // R1 no gate
        step(4'd5, ~^4'd5, 1'b1, 8'h11, ^8'h11, 1'b0, 1'b0, 1'b0); // R10 parity error
        step(4'd3, ~^4'd3, 1'b1, 8'd1 << LA, (^(8'd1 << LA)), 1'b1, 1'b0, 1'b0); // R10 bad select
        idle();
        do_reset();
        // constrained random
        for (int n = 0; n < 4000; n++) begin
            logic [3:0] c;
            logic [7:0] bo;
            int k;
            if (n % 250 == 249) do_reset();
            k = $urandom_range(0, 9);
            c = (k < 3) ? 4'd3 : (k < 5) ? 4'd2 : (k < 6) ? 4'd11 : (k < 7) ? 4'd9
                                                      : 4'($urandom_range(0, 15));
            k = $urandom_range(0, 3);
            bo = (k < 2) ? (8'd1 << $urandom_range(0, 7)) : 8'($urandom_range(0, 255));
            step(c,
                 ($urandom_range(0, 19) == 0) ? (^c) : (~^c),
                 $urandom_range(0, 7) != 0,
                 bo,
                 ($urandom_range(0, 49) == 0) ? (^bo) : (~^bo),
                 $urandom_range(0, 3) != 0,
                 $urandom_range(0, 5) == 0,
                 $urandom_range(0, 1) == 1);
        end
        done = 1;
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

endmodule